// File: doc/BRIEF.md
# Four-Wide Speculative Decode Stage with Scoreboard Gating

This block is the decode stage of a superscalar front end. Each cycle it takes one cache block of four instruction slots. A start-slot offset says where in the block execution enters. Each slot comes with a few predecoded fields. The stage walks the slots in program order and issues the ones that can go. If it finds a branch it expects to be taken, it steers the fetch address to the branch target straight away. The target block is then decoded in the very next cycle, without waiting for the branch to execute.

Branch direction comes from a fixed rule. Unconditional branches always redirect. A conditional branch is predicted taken when its target lies at or below its own address (a backward branch) and not taken otherwise. The slot directly after a taken branch is its delay slot and still issues. Any later slots in that block are dropped. When the branch sits in the last slot, its delay slot lies in the next sequential block, so the redirect is held back by one block.

Issue is gated by a scoreboard with one pending bit per register. An instruction whose destination already has a pending write causes an in-order stall. The slots before it issue, and decoding restarts at the stalled slot on a later cycle. Writeback ports release bits. A mispredict flush cancels everything decoded in that cycle, loads the corrected fetch address and releases the scoreboard bits named by the flush.

Top module: `spec_decoder`

## Requirements
- R1: During and right after reset, `fetch_addr` equals `RESET_ADDR`, every scoreboard bit is clear, `stall` is low, and with no block presented `iss_valid` is zero.
- R2: When a block holds no taken branch and no conflict, every valid slot at or above `blk_start` issues: slot i drives bit i of `iss_valid` and address `blk_base+i` in `iss_pc[i*AW +: AW]`. Slots below the start are not issued. The next `fetch_addr` is `blk_base+NSLOT`.
- R3: An unconditional branch in slot b (b < NSLOT-1) issues slots up to b+1 and drops the later ones. The next `fetch_addr` is its target.
- R4: A conditional branch whose target is at or below its own address is predicted taken, with the same effect as R3. A conditional branch with a higher target is predicted not taken, and the block continues as in R2.
- R5: A taken branch in the last slot makes the next `fetch_addr` equal `blk_base+NSLOT`. That next block then issues only its start slot, and the fetch after it is the branch target.
- R6: Issuing a slot whose write-enable bit is set sets the scoreboard bit of its destination register (`slot_dst[i*RW +: RW]`). A later instruction that writes the same register is not issued while that bit is set.
- R7: The stall is in order. Slots before the first conflicting slot issue, `stall` goes high, and the next `fetch_addr` is `blk_base` plus the conflicting slot index. A second write to the same register within one block is a conflict too.
- R8: A writeback on port k (`wb_en[k]`, register `wb_reg[k*RW +: RW]`) clears that register's bit at the next edge. If a writeback and a newly issued write hit the same register in the same cycle, the bit stays set.
- R9: Conflicts are judged on the registered scoreboard, so a writeback in the same cycle does not let the conflicting slot issue in that cycle.
- R10: If the conflicting slot is the delay slot of a taken branch, the stage stalls there. On the retry it issues only that delay slot, and the fetch after it is the branch target.
- R11: While `flush` is high nothing issues and `stall` is low. The next `fetch_addr` is `flush_addr`, any held-back redirect is dropped, and every register whose bit is set in `flush_clr` is released.
- R12: While `blk_valid` is low and there is no flush, nothing issues and `fetch_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | A cache block is presented this cycle |
| blk_base | input | AW | Address of slot 0 of the block |
| blk_start | input | SW | First slot to execute in the block |
| slot_v | input | NSLOT | Slot holds an instruction |
| slot_br | input | NSLOT | Slot is a branch |
| slot_unc | input | NSLOT | Branch is unconditional |
| slot_tgt | input | NSLOT*AW | Branch target per slot |
| slot_dst | input | NSLOT*RW | Destination register per slot |
| slot_wr | input | NSLOT | Slot writes its destination register |
| wb_en | input | NWB | Writeback port valid |
| wb_reg | input | NWB*RW | Register released per writeback port |
| flush | input | 1 | Mispredict flush |
| flush_addr | input | AW | Corrected fetch address |
| flush_clr | input | NREG | Registers whose pending writes were cancelled |
| fetch_addr | output | AW | Address of the block to present next |
| iss_valid | output | NSLOT | Slot issues this cycle |
| iss_pc | output | NSLOT*AW | Address of each slot |
| iss_dst | output | NSLOT*RW | Destination register of each slot |
| iss_wr | output | NSLOT | Issued slot writes a register |
| stall | output | 1 | In-order stall on a register conflict |

## Verification
The assertions assume the presented block is the one `fetch_addr` asked for. They also assume `blk_base` is aligned to `NSLOT`, no branch sits in a delay slot, and register indices stay below `NREG`. The directed tasks build every block from the current fetch address at an aligned base and keep branches out of delay slots. Each scenario opens with a flush that releases all registers, so the scoreboard state the checks rely on is always known. Writebacks are only sent for registers the scenario has made pending.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
   // source of the next fetch address
   typedef enum logic [2:0] {
      NXT_HOLD,
      NXT_SEQ,
      NXT_TGT,
      NXT_DEFER,
      NXT_PEND,
      NXT_RESUME,
      NXT_FLUSH
   } nxt_src_e;
endpackage

// File: rtl/sdec_predict.sv
module sdec_predict #(
   parameter int AW    = 16,
   parameter int NSLOT = 4,
   parameter bit BTFN  = 1'b1
) (
   input  logic [AW-1:0]       base,
   input  logic [NSLOT-1:0]    br,
   input  logic [NSLOT-1:0]    unc,
   input  logic [NSLOT*AW-1:0] tgt,
   output logic [NSLOT-1:0]    taken
);
   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      logic [AW-1:0] here;
      logic [AW-1:0] dest;
      assign here = base + AW'(i);
      assign dest = tgt[i*AW +: AW];
      if (BTFN) begin : g_btfn
         // backward (or self) targets predicted taken
         assign taken[i] = br[i] & (unc[i] | (dest <= here));
      end else begin : g_nt
         assign taken[i] = br[i] & unc[i];
      end
   end
endmodule

// File: rtl/sdec_scan.sv
module sdec_scan #(
   parameter int AW    = 16,
   parameter int NSLOT = 4,
   parameter int NREG  = 32,
   localparam int SW   = $clog2(NSLOT),
   localparam int RW   = $clog2(NREG)
) (
   input  logic                blk_valid,
   input  logic                kill,
   input  logic                pend,
   input  logic [SW-1:0]       start,
   input  logic [NSLOT-1:0]    v,
   input  logic [NSLOT-1:0]    wr,
   input  logic [NSLOT*RW-1:0] dst,
   input  logic [NSLOT-1:0]    taken,
   input  logic [NSLOT*AW-1:0] tgt,
   input  logic [NREG-1:0]     busy,
   output logic [NSLOT-1:0]    issue,
   output logic                conflict,
   output logic [SW-1:0]       cidx,
   output logic                red_found,
   output logic                red_last,
   output logic [AW-1:0]       red_tgt
);
   always_comb begin
      logic [NREG-1:0] wmask;
      logic [RW-1:0]   d;
      logic            stop;
      int              cut;
      issue     = '0;
      conflict  = 1'b0;
      cidx      = '0;
      red_found = 1'b0;
      red_last  = 1'b0;
      red_tgt   = '0;
      wmask     = '0;
      d         = '0;
      stop      = 1'b0;
      // in held-redirect mode only the start slot (delay slot) may issue
      cut       = pend ? int'(start) + 1 : NSLOT;
      if (blk_valid && !kill) begin
         for (int i = 0; i < NSLOT; i++) begin
            d = dst[i*RW +: RW];
            if (!stop && i >= int'(start) && i < cut && v[i]) begin
               if (wr[i] && (busy[d] || wmask[d])) begin
                  conflict = 1'b1;
                  cidx     = SW'(i);
                  stop     = 1'b1;
               end else begin
                  issue[i] = 1'b1;
                  if (wr[i]) wmask[d] = 1'b1;
                  if (!pend && !red_found && taken[i]) begin
                     red_found = 1'b1;
                     red_tgt   = tgt[i*AW +: AW];
                     red_last  = (i == NSLOT - 1);
                     cut       = i + 2;
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/sdec_scoreboard.sv
module sdec_scoreboard #(
   parameter int NSLOT = 4,
   parameter int NREG  = 32,
   parameter int NWB   = 2,
   localparam int RW   = $clog2(NREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NSLOT-1:0]    set_en,
   input  logic [NSLOT*RW-1:0] set_dst,
   input  logic [NWB-1:0]      wb_en,
   input  logic [NWB*RW-1:0]   wb_reg,
   input  logic                flush,
   input  logic [NREG-1:0]     flush_clr,
   output logic [NREG-1:0]     busy
);
   logic [NREG-1:0] setm, clrm, busy_d;

   always_comb begin
      setm = '0;
      clrm = '0;
      for (int i = 0; i < NSLOT; i++)
         if (set_en[i]) setm[set_dst[i*RW +: RW]] = 1'b1;
      for (int k = 0; k < NWB; k++)
         if (wb_en[k]) clrm[wb_reg[k*RW +: RW]] = 1'b1;
      if (flush) clrm = clrm | flush_clr;
      // a new set overrides a same-cycle release
      busy_d = (busy & ~clrm) | setm;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) busy <= '0;
      else        busy <= busy_d;
   end
endmodule

// File: rtl/spec_decoder.sv
module spec_decoder
   import sdec_pkg::*;
#(
   parameter int           AW         = 16,
   parameter int           NSLOT      = 4,
   parameter int           NREG       = 32,
   parameter int           NWB        = 2,
   parameter bit           BTFN       = 1'b1,
   parameter logic [AW-1:0] RESET_ADDR = 16'h0040,
   localparam int          SW         = $clog2(NSLOT),
   localparam int          RW         = $clog2(NREG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                blk_valid,
   input  logic [AW-1:0]       blk_base,
   input  logic [SW-1:0]       blk_start,
   input  logic [NSLOT-1:0]    slot_v,
   input  logic [NSLOT-1:0]    slot_br,
   input  logic [NSLOT-1:0]    slot_unc,
   input  logic [NSLOT*AW-1:0] slot_tgt,
   input  logic [NSLOT*RW-1:0] slot_dst,
   input  logic [NSLOT-1:0]    slot_wr,
   input  logic [NWB-1:0]      wb_en,
   input  logic [NWB*RW-1:0]   wb_reg,
   input  logic                flush,
   input  logic [AW-1:0]       flush_addr,
   input  logic [NREG-1:0]     flush_clr,
   output logic [AW-1:0]       fetch_addr,
   output logic [NSLOT-1:0]    iss_valid,
   output logic [NSLOT*AW-1:0] iss_pc,
   output logic [NSLOT*RW-1:0] iss_dst,
   output logic [NSLOT-1:0]    iss_wr,
   output logic                stall
);
   if (NSLOT < 2 || (1 << SW) != NSLOT) begin : g_bad_slots
      $error("NSLOT must be a power of two, at least 2");
   end
   if (NREG < 2 || (1 << RW) != NREG) begin : g_bad_regs
      $error("NREG must be a power of two, at least 2");
   end
   if (NWB < 1) begin : g_bad_wb
      $error("NWB must be at least 1");
   end
   if (AW <= SW) begin : g_bad_aw
      $error("AW too narrow for NSLOT");
   end

   logic [AW-1:0]    pc_q, pc_d;
   logic             pend_q, pend_d;
   logic [AW-1:0]    ptgt_q, ptgt_d;
   logic [NSLOT-1:0] taken, issue;
   logic             conflict, red_found, red_last;
   logic [SW-1:0]    cidx;
   logic [AW-1:0]    red_tgt;
   logic [NREG-1:0]  sb_state;
   nxt_src_e         src;

   sdec_predict #(.AW(AW), .NSLOT(NSLOT), .BTFN(BTFN)) u_pred (
      .base  (blk_base),
      .br    (slot_br),
      .unc   (slot_unc),
      .tgt   (slot_tgt),
      .taken (taken)
   );

   sdec_scan #(.AW(AW), .NSLOT(NSLOT), .NREG(NREG)) u_scan (
      .blk_valid (blk_valid),
      .kill      (flush),
      .pend      (pend_q),
      .start     (blk_start),
      .v         (slot_v),
      .wr        (slot_wr),
      .dst       (slot_dst),
      .taken     (taken),
      .tgt       (slot_tgt),
      .busy      (sb_state),
      .issue     (issue),
      .conflict  (conflict),
      .cidx      (cidx),
      .red_found (red_found),
      .red_last  (red_last),
      .red_tgt   (red_tgt)
   );

   sdec_scoreboard #(.NSLOT(NSLOT), .NREG(NREG), .NWB(NWB)) u_sb (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (issue & slot_wr),
      .set_dst   (slot_dst),
      .wb_en     (wb_en),
      .wb_reg    (wb_reg),
      .flush     (flush),
      .flush_clr (flush_clr),
      .busy      (sb_state)
   );

   // choose where the next block comes from
   always_comb begin
      if (flush)                       src = NXT_FLUSH;
      else if (!blk_valid)             src = NXT_HOLD;
      else if (conflict)               src = NXT_RESUME;
      else if (pend_q)                 src = NXT_PEND;
      else if (red_found && red_last)  src = NXT_DEFER;
      else if (red_found)              src = NXT_TGT;
      else                             src = NXT_SEQ;
   end

   always_comb begin
      pc_d   = pc_q;
      pend_d = pend_q;
      ptgt_d = ptgt_q;
      unique case (src)
         NXT_FLUSH:  begin pc_d = flush_addr; pend_d = 1'b0; end
         NXT_HOLD:   ;
         NXT_RESUME: begin
            pc_d = blk_base + AW'(cidx);
            // stalled in the delay slot of a branch found now
            if (red_found) begin pend_d = 1'b1; ptgt_d = red_tgt; end
         end
         NXT_PEND:   begin pc_d = ptgt_q; pend_d = 1'b0; end
         NXT_DEFER:  begin
            pc_d = blk_base + AW'(NSLOT);
            pend_d = 1'b1;
            ptgt_d = red_tgt;
         end
         NXT_TGT:    pc_d = red_tgt;
         default:    pc_d = blk_base + AW'(NSLOT);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q   <= RESET_ADDR;
         pend_q <= 1'b0;
         ptgt_q <= '0;
      end else begin
         pc_q   <= pc_d;
         pend_q <= pend_d;
         ptgt_q <= ptgt_d;
      end
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_out
      assign iss_pc[i*AW +: AW] = blk_base + AW'(i);
   end

   assign fetch_addr = pc_q;
   assign iss_valid  = issue;
   assign iss_dst    = slot_dst;
   assign iss_wr     = issue & slot_wr;
   assign stall      = conflict;
endmodule

// File: rtl/spec_decoder_sva.sv
module spec_decoder_sva #(
   parameter int  AW    = 16,
   parameter int  NSLOT = 4,
   parameter int  NREG  = 32,
   localparam int RW    = $clog2(NREG)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                flush,
   input logic [AW-1:0]       flush_addr,
   input logic                blk_valid,
   input logic [AW-1:0]       blk_base,
   input logic [AW-1:0]       fetch_addr,
   input logic [NSLOT-1:0]    iss_valid,
   input logic [NSLOT*RW-1:0] iss_dst,
   input logic [NSLOT-1:0]    iss_wr,
   input logic                stall,
   input logic [NREG-1:0]     sb_state
);
   p_flush_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> fetch_addr == $past(flush_addr));

   p_flush_cancel_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (iss_valid == '0 && !stall));

   p_resume_in_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !flush) |=> (fetch_addr >= $past(blk_base) &&
                             fetch_addr <  $past(blk_base) + AW'(NSLOT)));

   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!blk_valid && !flush) |=> $stable(fetch_addr));

   p_idle_no_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_valid |-> iss_valid == '0);

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      p_issue_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_valid[i] && iss_wr[i]) |-> !sb_state[iss_dst[i*RW +: RW]]);

      p_set_after_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_valid[i] && iss_wr[i]) |=> sb_state[$past(iss_dst[i*RW +: RW])]);
   end
endmodule

bind spec_decoder spec_decoder_sva #(.AW(AW), .NSLOT(NSLOT), .NREG(NREG)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .flush_addr (flush_addr),
   .blk_valid  (blk_valid),
   .blk_base   (blk_base),
   .fetch_addr (fetch_addr),
   .iss_valid  (iss_valid),
   .iss_dst    (iss_dst),
   .iss_wr     (iss_wr),
   .stall      (stall),
   .sb_state   (sb_state)
);

// File: tb/spec_decoder_test.sv
module spec_decoder_test;
   localparam int AW = 16, NSLOT = 4, NREG = 32, NWB = 2;
   localparam int SW = 2, RW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic                blk_valid;
   logic [AW-1:0]       blk_base;
   logic [SW-1:0]       blk_start;
   logic [NSLOT-1:0]    slot_v, slot_br, slot_unc, slot_wr;
   logic [NSLOT*AW-1:0] slot_tgt;
   logic [NSLOT*RW-1:0] slot_dst;
   logic [NWB-1:0]      wb_en;
   logic [NWB*RW-1:0]   wb_reg;
   logic                flush;
   logic [AW-1:0]       flush_addr;
   logic [NREG-1:0]     flush_clr;
   logic [AW-1:0]       fetch_addr;
   logic [NSLOT-1:0]    iss_valid, iss_wr;
   logic [NSLOT*AW-1:0] iss_pc;
   logic [NSLOT*RW-1:0] iss_dst;
   logic                stall;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   spec_decoder uut (
      .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_base(blk_base),
      .blk_start(blk_start), .slot_v(slot_v), .slot_br(slot_br),
      .slot_unc(slot_unc), .slot_tgt(slot_tgt), .slot_dst(slot_dst),
      .slot_wr(slot_wr), .wb_en(wb_en), .wb_reg(wb_reg), .flush(flush),
      .flush_addr(flush_addr), .flush_clr(flush_clr), .fetch_addr(fetch_addr),
      .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_dst(iss_dst),
      .iss_wr(iss_wr), .stall(stall)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      blk_valid = 1'b0; blk_base = '0; blk_start = '0;
      slot_v = '0; slot_br = '0; slot_unc = '0; slot_wr = '0;
      slot_tgt = '0; slot_dst = '0; wb_en = '0; wb_reg = '0;
      flush = 1'b0; flush_addr = '0; flush_clr = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic slot(int i, bit br, bit unc, logic [AW-1:0] tgt,
                       logic [RW-1:0] dst, bit wr);
      slot_v[i] = 1'b1; slot_br[i] = br; slot_unc[i] = unc;
      slot_tgt[i*AW +: AW] = tgt; slot_dst[i*RW +: RW] = dst; slot_wr[i] = wr;
   endtask

   task automatic blk(logic [AW-1:0] base, logic [SW-1:0] st);
      idle();
      blk_valid = 1'b1; blk_base = base; blk_start = st;
   endtask

   task automatic wb(int k, logic [RW-1:0] r);
      wb_en[k] = 1'b1; wb_reg[k*RW +: RW] = r;
   endtask

   task automatic settle();
      #1;
   endtask

   // flush that releases every register and jumps to addr
   task automatic go_to(logic [AW-1:0] addr);
      idle();
      flush = 1'b1; flush_addr = addr; flush_clr = '1;
      step();
      idle();
      chk("R11 flush target", 32'(fetch_addr), 32'(addr));
   endtask

   task automatic t_reset();
      chk("R1 reset fetch", 32'(fetch_addr), 32'h40);
      chk("R1 reset stall", 32'(stall), 0);
      chk("R1 reset no issue", 32'(iss_valid), 0);
      // empty scoreboard: writes to any register issue
      blk(16'h40, 0);
      slot(0, 0, 0, 0, 5'd0, 1); slot(1, 0, 0, 0, 5'd31, 1);
      settle();
      chk("R1 scoreboard empty", 32'(iss_valid), 32'b0011);
      idle();
   endtask

   task automatic t_seq();
      go_to(16'h40);
      blk(16'h40, 2'd1);
      for (int i = 0; i < NSLOT; i++) slot(i, 0, 0, 0, 5'(1 + i), 1);
      settle();
      chk("R2 issue from start", 32'(iss_valid), 32'b1110);
      chk("R2 slot pc", 32'(iss_pc[2*AW +: AW]), 32'h42);
      chk("R2 no stall", 32'(stall), 0);
      step();
      chk("R2 sequential fetch", 32'(fetch_addr), 32'h44);
      idle(); settle();
      chk("R12 idle no issue", 32'(iss_valid), 0);
      step();
      chk("R12 idle holds fetch", 32'(fetch_addr), 32'h44);
   endtask

   task automatic t_uncond();
      go_to(16'h80);
      blk(16'h80, 0);
      for (int i = 0; i < NSLOT; i++) slot(i, 0, 0, 0, 0, 0);
      slot(1, 1, 1, 16'h200, 0, 0);
      settle();
      chk("R3 delay slot kept, rest dropped", 32'(iss_valid), 32'b0111);
      step();
      chk("R3 redirect to target", 32'(fetch_addr), 32'h200);
   endtask

   task automatic t_cond();
      go_to(16'h100);
      blk(16'h100, 0);
      for (int i = 0; i < NSLOT; i++) slot(i, 0, 0, 0, 0, 0);
      slot(0, 1, 0, 16'h0c0, 0, 0);
      settle();
      chk("R4 backward taken issue", 32'(iss_valid), 32'b0011);
      step();
      chk("R4 backward taken fetch", 32'(fetch_addr), 32'h0c0);
      go_to(16'h100);
      blk(16'h100, 0);
      for (int i = 0; i < NSLOT; i++) slot(i, 0, 0, 0, 0, 0);
      slot(0, 1, 0, 16'h180, 0, 0);
      settle();
      chk("R4 forward not taken issue", 32'(iss_valid), 32'b1111);
      step();
      chk("R4 forward not taken fetch", 32'(fetch_addr), 32'h104);
   endtask

   task automatic t_last();
      go_to(16'h300);
      blk(16'h300, 0);
      for (int i = 0; i < NSLOT; i++) slot(i, 0, 0, 0, 0, 0);
      slot(3, 1, 1, 16'h500, 0, 0);
      settle();
      chk("R5 last-slot branch issues all", 32'(iss_valid), 32'b1111);
      step();
      chk("R5 fetch delay-slot block", 32'(fetch_addr), 32'h304);
      blk(16'h304, 0);
      for (int i = 0; i < NSLOT; i++) slot(i, 0, 0, 0, 0, 0);
      settle();
      chk("R5 only delay slot issues", 32'(iss_valid), 32'b0001);
      step();
      chk("R5 then target", 32'(fetch_addr), 32'h500);
   endtask

   task automatic t_scoreboard();
      go_to(16'h400);
      blk(16'h400, 0);
      slot(0, 0, 0, 0, 5'd5, 1); slot(1, 0, 0, 0, 5'd6, 1);
      settle();
      chk("R6 writers issue", 32'(iss_valid), 32'b0011);
      step();
      chk("R6 fetch next", 32'(fetch_addr), 32'h404);
      blk(16'h404, 0);
      slot(0, 0, 0, 0, 5'd7, 1); slot(1, 0, 0, 0, 5'd5, 1); slot(2, 0, 0, 0, 5'd8, 1);
      settle();
      chk("R6 R7 busy register blocks", 32'(iss_valid), 32'b0001);
      chk("R7 stall raised", 32'(stall), 1);
      step();
      chk("R7 resume at conflict", 32'(fetch_addr), 32'h405);
      go_to(16'h500);
      blk(16'h500, 0);
      slot(0, 0, 0, 0, 5'd9, 1); slot(1, 0, 0, 0, 5'd1, 0); slot(2, 0, 0, 0, 5'd9, 1);
      settle();
      chk("R7 same-block duplicate issue", 32'(iss_valid), 32'b0011);
      chk("R7 same-block duplicate stall", 32'(stall), 1);
      step();
      chk("R7 same-block resume", 32'(fetch_addr), 32'h502);
   endtask

   task automatic t_writeback();
      go_to(16'h600);
      blk(16'h600, 0);
      slot(0, 0, 0, 0, 5'd10, 1);
      step();
      blk(16'h604, 0);
      slot(0, 0, 0, 0, 5'd10, 1);
      wb(1, 5'd10);
      settle();
      chk("R9 same-cycle release no issue", 32'(iss_valid), 0);
      chk("R9 same-cycle release stall", 32'(stall), 1);
      step();
      chk("R9 retry address", 32'(fetch_addr), 32'h604);
      blk(16'h604, 0);
      slot(0, 0, 0, 0, 5'd10, 1);
      settle();
      chk("R8 released register issues", 32'(iss_valid), 32'b0001);
      chk("R8 no stall", 32'(stall), 0);
      step();
      blk(16'h608, 0);
      slot(0, 0, 0, 0, 5'd11, 1);
      wb(0, 5'd11);
      step();
      blk(16'h60c, 0);
      slot(0, 0, 0, 0, 5'd11, 1);
      settle();
      chk("R8 set wins over release", 32'(stall), 1);
      idle();
   endtask

   task automatic t_delay_conflict();
      go_to(16'h700);
      blk(16'h700, 0);
      slot(0, 0, 0, 0, 5'd12, 1);
      step();
      blk(16'h704, 0);
      slot(0, 1, 1, 16'h900, 0, 0); slot(1, 0, 0, 0, 5'd12, 1);
      slot(2, 0, 0, 0, 0, 0);
      settle();
      chk("R10 branch issues, delay slot stalls", 32'(iss_valid), 32'b0001);
      chk("R10 stall", 32'(stall), 1);
      step();
      chk("R10 resume at delay slot", 32'(fetch_addr), 32'h705);
      idle();
      wb(0, 5'd12);
      step();
      chk("R12 hold during writeback", 32'(fetch_addr), 32'h705);
      blk(16'h704, 2'd1);
      slot(1, 0, 0, 0, 5'd12, 1); slot(2, 0, 0, 0, 0, 0); slot(3, 0, 0, 0, 0, 0);
      settle();
      chk("R10 only delay slot on retry", 32'(iss_valid), 32'b0010);
      step();
      chk("R10 then target", 32'(fetch_addr), 32'h900);
   endtask

   task automatic t_flush();
      go_to(16'ha00);
      blk(16'ha00, 0);
      slot(0, 0, 0, 0, 5'd13, 1);
      step();
      blk(16'ha04, 0);
      slot(0, 0, 0, 0, 5'd14, 1);
      flush = 1'b1; flush_addr = 16'hb00; flush_clr = 32'h1 << 13;
      settle();
      chk("R11 flush cancels issue", 32'(iss_valid), 0);
      chk("R11 flush no stall", 32'(stall), 0);
      step();
      chk("R11 flush fetch", 32'(fetch_addr), 32'hb00);
      blk(16'hb00, 0);
      slot(0, 0, 0, 0, 5'd13, 1); slot(1, 0, 0, 0, 5'd14, 1);
      settle();
      chk("R11 released and unset regs issue", 32'(iss_valid), 32'b0011);
      chk("R11 no stall after flush", 32'(stall), 0);
      step();
      go_to(16'hc00);
      blk(16'hc00, 0);
      for (int i = 0; i < NSLOT; i++) slot(i, 0, 0, 0, 0, 0);
      slot(3, 1, 1, 16'he00, 0, 0);
      step();
      chk("R5 deferred redirect armed", 32'(fetch_addr), 32'hc04);
      idle();
      flush = 1'b1; flush_addr = 16'hd00;
      step();
      blk(16'hd00, 0);
      for (int i = 0; i < NSLOT; i++) slot(i, 0, 0, 0, 0, 0);
      settle();
      chk("R11 held redirect dropped issue", 32'(iss_valid), 32'b1111);
      step();
      chk("R11 held redirect dropped fetch", 32'(fetch_addr), 32'hd04);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 fetch during reset", 32'(fetch_addr), 32'h40);
      rst_n = 1'b1;
      step();
      t_reset();
      t_seq();
      t_uncond();
      t_cond();
      t_last();
      t_scoreboard();
      t_writeback();
      t_delay_conflict();
      t_flush();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule